// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block sits on the host side of a 16-bit-word serial EEPROM link. It drives chip select, the serial clock and the serial data line towards the memory, and samples the data line coming back from it. A request port takes a command code, a 6-bit word address and a 16-bit write word, using a valid/ready handshake. The block turns each request into a serial frame and, for reads, returns the word that was read. It raises a one-cycle completion pulse when the transaction has ended.

Each frame opens with a start bit, then an opcode and an address, and then data bits for the write-type commands. The serial clock is derived from the system clock with a parameterised half-period. Commands that program the array end with status polling. The block drops select for a minimum low time, raises it again and waits until the memory signals ready on its data output. A timeout counter bounds this wait. An output-enable signal marks the cycles in which the host drives the data wire, so the same controller can serve a link where data in and data out share one wire.

Top module: `mw_eeprom_host`

## Requirements
- R1: A frame starts with `cs` rising and `di` = 1 (start bit), followed by 2 opcode bits and 6 address bits, most significant bit first. `di` changes only while `sclk` is low and is held steady while `sclk` is high.
- R2: `req_cmd` codes are 0 READ, 1 WRITE, 2 ERASE, 3 EWEN, 4 EWDS, 5 ERAL, 6 WRAL. Opcodes are READ 10, WRITE 01, ERASE 11, and 00 for the rest. Under opcode 00, the top two address bits select EWEN 11, EWDS 00, ERAL 10 and WRAL 01, and the lower address bits are sent as 0.
- R3: WRITE and WRAL send 25 bits, the last 16 being the write word with bit 15 first. ERASE, EWEN, EWDS and ERAL send 9 bits. Each bit lasts 2*DIV_HALF system clocks.
- R4: A READ clocks in 17 further bits, sampling `do_in` on each rising `sclk` edge. The first sample is discarded and the next 16 form `rsp_rdata`, bit 15 first. A READ completes exactly 2*DIV_HALF*26 + CS_LOW_MIN cycles after acceptance.
- R5: After WRITE, ERASE, ERAL or WRAL, `cs` is held low for CS_LOW_MIN cycles and then raised. The block waits until `do_in` reads 1, drops `cs`, holds it low for CS_LOW_MIN cycles and completes with `rsp_err` = 0.
- R6: `di_oe` is 1 only while command, address or write bits are being sent. It is 0 during the read data bits and during polling.
- R7: If `do_in` stays 0 for POLL_LIMIT polling cycles, `rsp_err` is 1 at completion. Completion then comes exactly 2*DIV_HALF*N + 2*CS_LOW_MIN + POLL_LIMIT cycles after acceptance, where N is the frame length.
- R8: `req_ready` is 1 only when idle, with `cs` and `sclk` low. A `req_valid` raised during a transaction has no effect.
- R9: After reset, `cs`, `sclk` and `rsp_done` are 0 and `req_ready` is 1.
- R10: EWEN and EWDS have no polling phase and complete exactly 2*DIV_HALF*9 + CS_LOW_MIN cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_cmd | input | 3 | Command code (see R2) |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Write word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last word read |
| rsp_err | output | 1 | Poll timeout flag, valid with `rsp_done` |
| cs | output | 1 | Chip select to the memory |
| sclk | output | 1 | Serial clock to the memory |
| di | output | 1 | Serial data to the memory |
| di_oe | output | 1 | Host drives the data wire |
| do_in | input | 1 | Serial data / status from the memory |

## Verification
Each completion time is fixed by the frame length. A 9-bit command is due 2*DIV_HALF*9 + CS_LOW_MIN edges after the accepting edge. A READ is due 2*DIV_HALF*26 + CS_LOW_MIN edges after it, and a timed-out poll 2*DIV_HALF*N + 2*CS_LOW_MIN + POLL_LIMIT edges after it. The bench counts rising edges from the accepting edge, samples on the falling edge, and compares the count at the first `rsp_done` against these figures. A behavioural memory model answers the frames, and read data is judged against a vector table. Drive-enable and select are sampled at fixed edge offsets inside the read-data and polling phases.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 16;
    localparam int OP_W    = 2;
    localparam int HDR_W   = 1 + OP_W + ADDR_W;
    localparam int FRAME_W = HDR_W + DATA_W;

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_ERASE = 3'd2,
        CMD_EWEN  = 3'd3,
        CMD_EWDS  = 3'd4,
        CMD_ERAL  = 3'd5,
        CMD_WRAL  = 3'd6
    } mw_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_RDATA,
        ST_CSLOW,
        ST_POLL
    } mw_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [5:0]         nbits;
        logic               is_read;
        logic               is_prog;
    } mw_frame_t;

    function automatic logic [ADDR_W-1:0] special_addr(input logic [1:0] sel);
        return {sel, {(ADDR_W-2){1'b0}}};
    endfunction

    function automatic mw_frame_t build_frame(input logic [2:0] cmd,
                                              input logic [ADDR_W-1:0] addr,
                                              input logic [DATA_W-1:0] wdata);
        mw_frame_t f;
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
        logic              long_f;
        op = 2'b00;
        a  = addr;
        d  = '0;
        long_f = 1'b0;
        f.is_read = 1'b0;
        f.is_prog = 1'b0;
        case (mw_cmd_e'(cmd))
            CMD_READ:  begin op = 2'b10; f.is_read = 1'b1; end
            CMD_WRITE: begin op = 2'b01; d = wdata; long_f = 1'b1; f.is_prog = 1'b1; end
            CMD_ERASE: begin op = 2'b11; f.is_prog = 1'b1; end
            CMD_EWEN:  a = special_addr(2'b11);
            CMD_ERAL:  begin a = special_addr(2'b10); f.is_prog = 1'b1; end
            CMD_WRAL:  begin a = special_addr(2'b01); d = wdata; long_f = 1'b1; f.is_prog = 1'b1; end
            default:   a = special_addr(2'b00);
        endcase
        f.bits  = {1'b1, op, a, d};
        f.nbits = long_f ? 6'(FRAME_W) : 6'(HDR_W);
        return f;
    endfunction

endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(DIV_HALF + 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(DIV_HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !en || tick) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mw_tx_shift.sv
module mw_tx_shift #(
    parameter int WIDTH = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] frame,
    input  logic             shift,
    output logic             bit_out
);
    logic [WIDTH-1:0] sh;

    assign bit_out = sh[WIDTH-1];

    always_ff @(posedge clk) begin
        if (rst)        sh <= '0;
        else if (load)  sh <= frame;
        else if (shift) sh <= {sh[WIDTH-2:0], 1'b0};
    end
endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)         word <= '0;
        else if (sample) word <= {word[WIDTH-2:0], bit_in};
    end
endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
    import mw_pkg::*;
#(
    parameter int DIV_HALF   = 2,
    parameter int CS_LOW_MIN = 3,
    parameter int POLL_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              cs,
    output logic              sclk,
    output logic              di,
    output logic              di_oe,
    input  logic              do_in
);
    localparam int LW = $clog2(CS_LOW_MIN + 1);
    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam int BW = $clog2(FRAME_W + 1);

    mw_state_e       state;
    mw_frame_t       fr;
    logic [BW-1:0]   bits_left;
    logic [LW-1:0]   low_cnt;
    logic [PW-1:0]   poll_cnt;
    logic            is_read, poll_pend, err_pend;
    logic            tick, accept, tx_shift, rx_sample;

    assign fr        = build_frame(req_cmd, req_addr, req_wdata);
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign di_oe     = (state == ST_SHIFT);
    assign tx_shift  = (state == ST_SHIFT) && tick && sclk && (bits_left != '0);
    assign rx_sample = (state == ST_RDATA) && tick && !sclk;

    mw_tick_gen #(.DIV_HALF(DIV_HALF)) i_tick (
        .clk(clk), .rst(rst),
        .en((state == ST_SHIFT) || (state == ST_RDATA)),
        .tick(tick)
    );

    mw_tx_shift #(.WIDTH(FRAME_W)) i_tx (
        .clk(clk), .rst(rst), .load(accept), .frame(fr.bits),
        .shift(tx_shift), .bit_out(di)
    );

    mw_rx_shift #(.WIDTH(DATA_W)) i_rx (
        .clk(clk), .rst(rst), .sample(rx_sample), .bit_in(do_in),
        .word(rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cs        <= 1'b0;
            sclk      <= 1'b0;
            bits_left <= '0;
            low_cnt   <= '0;
            poll_cnt  <= '0;
            is_read   <= 1'b0;
            poll_pend <= 1'b0;
            err_pend  <= 1'b0;
            rsp_done  <= 1'b0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state     <= ST_SHIFT;
                        cs        <= 1'b1;
                        sclk      <= 1'b0;
                        bits_left <= BW'(fr.nbits - 6'd1);
                        is_read   <= fr.is_read;
                        poll_pend <= fr.is_prog;
                        err_pend  <= 1'b0;
                        rsp_err   <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk <= ~sclk;
                        if (sclk) begin
                            if (bits_left == '0) begin
                                if (is_read) begin
                                    state     <= ST_RDATA;
                                    bits_left <= BW'(DATA_W);
                                end else begin
                                    state   <= ST_CSLOW;
                                    cs      <= 1'b0;
                                    low_cnt <= '0;
                                end
                            end else begin
                                bits_left <= bits_left - 1'b1;
                            end
                        end
                    end
                end
                ST_RDATA: begin
                    if (tick) begin
                        sclk <= ~sclk;
                        if (sclk) begin
                            if (bits_left == '0) begin
                                state   <= ST_CSLOW;
                                cs      <= 1'b0;
                                low_cnt <= '0;
                            end else begin
                                bits_left <= bits_left - 1'b1;
                            end
                        end
                    end
                end
                ST_CSLOW: begin
                    if (low_cnt == LW'(CS_LOW_MIN - 1)) begin
                        if (poll_pend) begin
                            state     <= ST_POLL;
                            cs        <= 1'b1;
                            poll_cnt  <= '0;
                            poll_pend <= 1'b0;
                        end else begin
                            state    <= ST_IDLE;
                            rsp_done <= 1'b1;
                            rsp_err  <= err_pend;
                        end
                    end else begin
                        low_cnt <= low_cnt + 1'b1;
                    end
                end
                ST_POLL: begin
                    if (do_in || (poll_cnt == PW'(POLL_LIMIT - 1))) begin
                        err_pend <= !do_in;
                        state    <= ST_CSLOW;
                        cs       <= 1'b0;
                        low_cnt  <= '0;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    initial begin
        if (CS_LOW_MIN < 2 || DIV_HALF < 1 || POLL_LIMIT < 1)
            $error("mw_eeprom_host: parameter out of range");
    end

    // R1: the start bit is a 1 on the data line when select rises
    a_r1_start_bit: assert property (@(posedge clk) disable iff (rst)
        ($rose(cs) && di_oe) |-> di);
    // R1: data line does not move while the serial clock is high
    a_r1_di_stable: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk) && di_oe && $past(di_oe)) |-> $stable(di));
    // R6: the host drives the wire only under select
    a_r6_drive_under_cs: assert property (@(posedge clk) disable iff (rst)
        di_oe |-> cs);
    // R8: requests are taken only with the link quiet
    a_r8_ready_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!cs && !sclk));
    // R3: no serial clock without select
    a_r3_sclk_needs_cs: assert property (@(posedge clk) disable iff (rst)
        !cs |-> !sclk);
    // R5: select stays low for at least two cycles after it drops
    a_r5_cs_low_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(cs) |=> !cs);
    // R4: completion is a single-cycle pulse
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
    // R7: the error flag appears together with completion
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_err) |-> rsp_done);
endmodule

// File: tb/test_mw_eeprom_host.sv
module test_mw_eeprom_host;
    localparam int D = 2;
    localparam int L = 3;
    localparam int P = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_cmd = 3'd0;
    logic [5:0]  req_addr = 6'd0;
    logic [15:0] req_wdata = 16'd0;
    logic        rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic        cs, sclk, di, di_oe, do_in;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mw_eeprom_host #(.DIV_HALF(D), .CS_LOW_MIN(L), .POLL_LIMIT(P)) i_mw_eeprom_host (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .cs(cs), .sclk(sclk), .di(di), .di_oe(di_oe), .do_in(do_in)
    );

    // behavioural memory model
    logic [15:0] mem [64];
    logic [24:0] sh;
    int          nb = 0;
    logic        started = 1'b0;
    logic        en = 1'b0;
    logic        rd_active = 1'b0;
    logic        rd_bit = 1'b0;
    logic [15:0] rd_word;
    logic [8:0]  hdr = '0;
    int          prog_count = 0;
    int          prog_seen = 0;
    int          busy = 0;
    int          busy_len = 20;

    assign do_in = rd_active ? rd_bit : (cs && busy == 0);

    always @(posedge sclk or negedge cs) begin
        if (!cs) begin
            started = 1'b0; nb = 0; rd_active = 1'b0;
        end else if (!started) begin
            if (di) begin started = 1'b1; nb = 0; sh = '0; end
        end else if (rd_active) begin
            rd_bit = rd_word[15];
            rd_word = {rd_word[14:0], 1'b0};
        end else if (nb < 99) begin
            sh = {sh[23:0], di};
            nb = nb + 1;
            if (nb == 8) begin
                hdr = {1'b1, sh[7:0]};
                case (sh[7:6])
                    2'b10: begin rd_active = 1'b1; rd_bit = 1'b0; rd_word = mem[sh[5:0]]; nb = 99; end
                    2'b11: begin if (en) begin mem[sh[5:0]] = 16'hFFFF; prog_count++; end nb = 99; end
                    2'b00: begin
                        case (sh[5:4])
                            2'b11: begin en = 1'b1; nb = 99; end
                            2'b00: begin en = 1'b0; nb = 99; end
                            2'b10: begin
                                if (en) begin
                                    for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
                                    prog_count++;
                                end
                                nb = 99;
                            end
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end else if (nb == 24) begin
                if (en) begin
                    if (sh[23:22] == 2'b01) mem[sh[21:16]] = sh[15:0];
                    else for (int i = 0; i < 64; i++) mem[i] = sh[15:0];
                    prog_count++;
                end
                nb = 99;
            end
        end
    end

    always @(posedge clk) begin
        if (prog_count != prog_seen) begin
            prog_seen <= prog_count;
            busy <= busy_len;
        end else if (busy > 0) begin
            busy <= busy - 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int frame_bits(input logic [2:0] c);
        return (c == 3'd1 || c == 3'd6) ? 25 : 9;
    endfunction

    // drive one request, return edges from acceptance to completion
    task automatic run_req(input logic [2:0] c, input logic [5:0] a, input logic [15:0] w,
                           output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_addr = a; req_wdata = w;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (rsp_done || lat > 20000) break;
        end
    endtask

    // cmd, addr, wdata, expected read word, read-check flag
    localparam logic [41:0] VEC [15] = '{
        {3'd3, 6'd0,  16'h0000, 16'h0000, 1'b0},
        {3'd1, 6'd5,  16'hA5A5, 16'h0000, 1'b0},
        {3'd0, 6'd5,  16'h0000, 16'hA5A5, 1'b1},
        {3'd1, 6'd63, 16'h1234, 16'h0000, 1'b0},
        {3'd0, 6'd63, 16'h0000, 16'h1234, 1'b1},
        {3'd2, 6'd5,  16'h0000, 16'h0000, 1'b0},
        {3'd0, 6'd5,  16'h0000, 16'hFFFF, 1'b1},
        {3'd5, 6'd0,  16'h0000, 16'h0000, 1'b0},
        {3'd0, 6'd63, 16'h0000, 16'hFFFF, 1'b1},
        {3'd6, 6'd0,  16'h0F0F, 16'h0000, 1'b0},
        {3'd0, 6'd0,  16'h0000, 16'h0F0F, 1'b1},
        {3'd0, 6'd42, 16'h0000, 16'h0F0F, 1'b1},
        {3'd4, 6'd0,  16'h0000, 16'h0000, 1'b0},
        {3'd1, 6'd7,  16'hBEEF, 16'h0000, 1'b0},
        {3'd0, 6'd7,  16'h0000, 16'h0F0F, 1'b1}
    };

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 cs", {31'd0, cs}, 32'd0);
        check("R9 sclk", {31'd0, sclk}, 32'd0);
        check("R9 ready", {31'd0, req_ready}, 32'd1);
        check("R9 done", {31'd0, rsp_done}, 32'd0);

        foreach (VEC[k]) begin
            logic [2:0]  c = VEC[k][41:39];
            logic [5:0]  a = VEC[k][38:33];
            logic [15:0] w = VEC[k][32:17];
            logic [15:0] e = VEC[k][16:1];
            int n = frame_bits(c);
            run_req(c, a, w, lat);
            if (c == 3'd0) begin
                check("R4 read latency", lat, 2 * D * 26 + L);
                if (VEC[k][0]) check("R4 read word", {16'd0, rsp_rdata}, {16'd0, e});
            end else if (c == 3'd3 || c == 3'd4) begin
                check("R10 enable/disable latency", lat, 2 * D * 9 + L);
                if (c == 3'd3) check("R1 R2 EWEN header", {23'd0, hdr}, {23'd0, 9'b1_00_110000});
            end else begin
                check("R5 poll completes without error", {31'd0, rsp_err}, 32'd0);
                check("R3 R5 program latency exceeds frame+gaps", {31'd0, lat > 2 * D * n + 2 * L}, 32'd1);
            end
        end

        // R2 R3: write header bits, re-enable then write and check header
        run_req(3'd3, 6'd0, 16'h0, lat);
        run_req(3'd1, 6'd9, 16'h8001, lat);
        check("R2 WRITE header", {23'd0, hdr}, {23'd0, 9'b1_01_001001});
        run_req(3'd0, 6'd9, 16'h0, lat);
        check("R3 write word order", {16'd0, rsp_rdata}, 32'h8001);

        // R7 poll timeout
        busy_len = 500;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 3'd2; req_addr = 6'd9;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 2 * D * 9 + L + 10) begin
                check("R6 no drive while polling", {31'd0, di_oe}, 32'd0);
                check("R5 cs high while polling", {31'd0, cs}, 32'd1);
            end
            if (rsp_done || lat > 20000) break;
        end
        check("R7 timeout latency", lat, 2 * D * 9 + 2 * L + P);
        check("R7 timeout error flag", {31'd0, rsp_err}, 32'd1);
        repeat (600) @(negedge clk);
        busy_len = 20;

        // R6 R8: mid-read drive enable, busy ready, stray request ignored
        run_req(3'd1, 6'd12, 16'h3C3C, lat);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 3'd0; req_addr = 6'd12;
        @(posedge clk);
        @(negedge clk);
        req_cmd = 3'd1; req_wdata = 16'h0000;
        lat = 0;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 2 * D * 9 + 5) begin
                check("R6 no drive during read data", {31'd0, di_oe}, 32'd0);
                check("R8 not ready mid-transaction", {31'd0, req_ready}, 32'd0);
            end
            if (rsp_done || lat > 20000) break;
        end
        req_valid = 1'b0;
        check("R4 read under stray request", {16'd0, rsp_rdata}, 32'h3C3C);
        check("R8 req_ready at completion", {31'd0, req_ready}, 32'd1);
        run_req(3'd0, 6'd12, 16'h0, lat);
        check("R8 stray write had no effect", {16'd0, rsp_rdata}, 32'h3C3C);
        check("R9 cs low when idle", {31'd0, cs}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule